// File: doc/BRIEF.md
# Event Capture/Compare Channel

This block is a single timer-driven event channel. It runs in one of two modes. In capture mode it watches an input pin for a chosen edge and stores the value of the selected timer in a two-slot queue. If a third capture arrives while both slots are full, an overrun flag is set. In compare mode it watches the selected timer for equality with a programmed time. When they first become equal, it drives its output pin according to the configured action, and it can pulse a request to reset the timer.

Software or a bus wrapper owns the configuration inputs and the time register access strobes. The timers are outside the block and arrive as plain values. A sticky pending flag reports every capture and every compare match, for use by interrupt logic that sits elsewhere.

Top module: `evt_chan`

## Requirements
- R1: With cfg_compare=0 a capture happens only on the pin transitions selected by cfg_edge: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. With cfg_compare=1 no pin transition is captured.
- R2: A capture stores timer_a when cfg_timer_sel=0 and timer_b when cfg_timer_sel=1. The stored value is the one present at the clock edge where pin_in is first sampled at its new level. Pin history resets to low.
- R3: The capture queue holds two entries, and cap_count never exceeds 2. A capture arriving with two entries held and no pop sets ovr. That capture replaces the newer entry and leaves the older entry intact.
- R4: In capture mode, time_rdata shows the oldest entry. A one-cycle time_rd with entries present removes that entry and moves the newer one forward. A pop and a capture in the same cycle keep the count unchanged and keep the order.
- R5: In compare mode the action fires once when the selected timer becomes equal to the compare time. A timer that stays equal does not fire it again. cfg_action 2'b00 leaves pin_out alone, 2'b01 sets it, 2'b10 clears it and 2'b11 inverts it. Outside compare mode pin_out holds.
- R6: timer_rst_req pulses for exactly one cycle after a compare action fires when cfg_rst_en=1. It stays low when cfg_rst_en=0.
- R7: time_wr loads time_wdata into the compare time. The new value is compared from the next cycle on, and time_rdata reads it back in compare mode.
- R8: pend is set by every capture and every compare firing. It holds until pend_clr, and a new event wins over a clear in the same cycle. ovr holds until ovr_clr.
- R9: After reset cap_count, pin_out, pend, ovr and timer_rst_req are 0, and the compare time is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_compare | input | 1 | 1 = compare mode, 0 = capture mode |
| cfg_timer_sel | input | 1 | Timer select: 0 = timer_a, 1 = timer_b |
| cfg_edge | input | 2 | Capture edge select |
| cfg_action | input | 2 | Compare pin action |
| cfg_rst_en | input | 1 | Request a timer reset on compare |
| timer_a | input | TW | First timer value |
| timer_b | input | TW | Second timer value |
| pin_in | input | 1 | Event input pin |
| time_wr | input | 1 | Write strobe for the compare time |
| time_wdata | input | TW | Compare time write data |
| time_rd | input | 1 | Pop strobe for the capture queue |
| pend_clr | input | 1 | Clear the pending flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| time_rdata | output | TW | Oldest capture, or the compare time in compare mode |
| cap_count | output | 2 | Entries held in the capture queue |
| pin_out | output | 1 | Compare output pin |
| timer_rst_req | output | 1 | One-cycle timer reset request |
| pend | output | 1 | Sticky event flag |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the channel with 8-bit timers, so every captured value and compare time can be picked by hand and told apart. That width lets it sweep all four edge settings against both starting pin levels. It also runs every compare action with and without the reset request over two rounds, so pin_out passes through both of its levels. It fills the queue past overrun, and it crosses a pop with a capture at the full level.

// File: rtl/evt_chan.sv
module evt_chan #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_compare,
  input  logic          cfg_timer_sel,
  input  logic [1:0]    cfg_edge,
  input  logic [1:0]    cfg_action,
  input  logic          cfg_rst_en,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          pin_in,
  input  logic          time_wr,
  input  logic [TW-1:0] time_wdata,
  input  logic          time_rd,
  input  logic          pend_clr,
  input  logic          ovr_clr,
  output logic [TW-1:0] time_rdata,
  output logic [1:0]    cap_count,
  output logic          pin_out,
  output logic          timer_rst_req,
  output logic          pend,
  output logic          ovr
);

  logic [TW-1:0] tsel, slot0, slot1, cmp_time;
  logic          pin_q, match_q;
  logic          rise, fall, cap, pop, match, hit, ovr_set;

  assign tsel    = cfg_timer_sel ? timer_b : timer_a;
  assign rise    = pin_in & ~pin_q;
  assign fall    = ~pin_in & pin_q;
  assign cap     = ~cfg_compare & ((cfg_edge[0] & rise) | (cfg_edge[1] & fall));
  assign pop     = ~cfg_compare & time_rd & (cap_count != 2'd0);
  assign match   = cfg_compare & (tsel == cmp_time);
  assign hit     = match & ~match_q;
  assign ovr_set = cap & ~pop & (cap_count == 2'd2);

  assign time_rdata = cfg_compare ? cmp_time : slot0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pin_q   <= pin_in;
      match_q <= match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0     <= '0;
      slot1     <= '0;
      cap_count <= 2'd0;
    end else begin
      case ({cap, pop})
        2'b10: begin
          if (cap_count == 2'd0) begin
            slot0     <= tsel;
            cap_count <= 2'd1;
          end else begin
            slot1     <= tsel;
            cap_count <= 2'd2;
          end
        end
        2'b01: begin
          slot0     <= slot1;
          cap_count <= cap_count - 2'd1;
        end
        2'b11: begin
          if (cap_count == 2'd1) begin
            slot0 <= tsel;
          end else begin
            slot0 <= slot1;
            slot1 <= tsel;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_time      <= '0;
      pin_out       <= 1'b0;
      timer_rst_req <= 1'b0;
    end else begin
      if (time_wr) cmp_time <= time_wdata;
      timer_rst_req <= hit & cfg_rst_en;
      if (hit) begin
        case (cfg_action)
          2'b01:   pin_out <= 1'b1;
          2'b10:   pin_out <= 1'b0;
          2'b11:   pin_out <= ~pin_out;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (cap | hit)    pend <= 1'b1;
      else if (pend_clr) pend <= 1'b0;
      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

endmodule

module evt_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_compare,
  input logic       pend,
  input logic       pend_clr,
  input logic       ovr,
  input logic [1:0] cap_count,
  input logic       pin_out,
  input logic       timer_rst_req
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cap_count != 2'd3); // R3

  AST_OVR_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(cap_count) == 2'd2); // R3

  AST_NO_CAP_IN_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_compare |=> $stable(cap_count)); // R1

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_compare |=> $stable(pin_out)); // R5

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst_req |=> !timer_rst_req); // R6

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !pend_clr |=> pend); // R8

endmodule

bind evt_chan evt_chan_chk u_evt_chan_chk (
  .clk(clk), .rst_n(rst_n), .cfg_compare(cfg_compare), .pend(pend),
  .pend_clr(pend_clr), .ovr(ovr), .cap_count(cap_count), .pin_out(pin_out),
  .timer_rst_req(timer_rst_req)
);

// File: tb/test_evt_chan.sv
module test_evt_chan;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_compare = 1'b0, cfg_timer_sel = 1'b0, cfg_rst_en = 1'b0;
  logic [1:0] cfg_edge = 2'b00, cfg_action = 2'b00;
  logic [TW-1:0] timer_a = '0, timer_b = '0, time_wdata = '0;
  logic pin_in = 1'b0, time_wr = 1'b0, time_rd = 1'b0, pend_clr = 1'b0, ovr_clr = 1'b0;
  logic [TW-1:0] time_rdata;
  logic [1:0] cap_count;
  logic pin_out, timer_rst_req, pend, ovr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_chan #(.TW(TW)) i_evt_chan (
    .clk(clk), .rst_n(rst_n), .cfg_compare(cfg_compare), .cfg_timer_sel(cfg_timer_sel),
    .cfg_edge(cfg_edge), .cfg_action(cfg_action), .cfg_rst_en(cfg_rst_en),
    .timer_a(timer_a), .timer_b(timer_b), .pin_in(pin_in), .time_wr(time_wr),
    .time_wdata(time_wdata), .time_rd(time_rd), .pend_clr(pend_clr), .ovr_clr(ovr_clr),
    .time_rdata(time_rdata), .cap_count(cap_count), .pin_out(pin_out),
    .timer_rst_req(timer_rst_req), .pend(pend), .ovr(ovr)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pop_one();
    time_rd = 1'b1; tick(); time_rd = 1'b0;
  endtask

  task automatic clear_pend();
    pend_clr = 1'b1; tick(); pend_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_pin;
    int pulses;
    repeat (3) tick();
    check("R9 count", cap_count, 0);
    check("R9 pin_out", pin_out, 0);
    check("R9 pend", pend, 0);
    check("R9 ovr", ovr, 0);
    check("R9 rst_req", timer_rst_req, 0);
    rst_n = 1'b1;
    tick();
    check("R9 pend after release", pend, 0);

    // R1/R2: every edge setting against both starting levels
    for (int e = 0; e < 4; e++) begin
      for (int l = 0; l < 2; l++) begin
        bit take;
        cfg_edge = 2'b00; pin_in = l[0]; tick();
        cfg_edge = e[1:0];
        timer_a = TW'(e * 16 + l + 3);
        pin_in = ~l[0]; tick();
        take = (l == 0) ? e[0] : e[1];
        check("R1 edge select", cap_count, int'(take));
        check("R8 pend on capture", pend, int'(take));
        if (take) check("R2 stamp", time_rdata, e * 16 + l + 3);
        if (cap_count != 0) pop_one();
        check("R4 drained", cap_count, 0);
        clear_pend();
      end
    end

    // R2: timer select
    cfg_edge = 2'b11;
    for (int s = 0; s < 2; s++) begin
      cfg_timer_sel = s[0];
      timer_a = 8'h11; timer_b = TW'(8'h22 + s);
      pin_in = ~pin_in; tick();
      check("R2 timer select", time_rdata, s ? 8'h22 + s : 8'h11);
      pop_one();
    end
    cfg_timer_sel = 1'b0;

    // R3/R4: fill, overrun, pop crossing capture
    for (int k = 0; k < 3; k++) begin
      timer_a = TW'(10 * (k + 1));
      pin_in = ~pin_in; tick();
      check("R3 count", cap_count, (k < 2) ? k + 1 : 2);
      check("R3 ovr", ovr, int'(k == 2));
      check("R3 oldest kept", time_rdata, 10);
    end
    timer_a = 40; pin_in = ~pin_in; time_rd = 1'b1; tick(); time_rd = 1'b0;
    check("R4 pop+capture count", cap_count, 2);
    check("R4 pop+capture order", time_rdata, 30);
    check("R3 no ovr on pop+capture", ovr, 1);
    pop_one();
    check("R4 pop forward", time_rdata, 40);
    check("R4 pop count", cap_count, 1);
    pop_one();
    check("R4 empty", cap_count, 0);
    check("R8 ovr sticky", ovr, 1);
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    check("R8 ovr clear", ovr, 0);

    // R8: event wins over clear
    clear_pend();
    timer_a = 7; pin_in = ~pin_in; pend_clr = 1'b1; tick(); pend_clr = 1'b0;
    check("R8 set wins", pend, 1);
    clear_pend();
    check("R8 clear", pend, 0);
    pop_one();

    // R1: no capture in compare mode; R7 readback
    timer_a = 5; cfg_compare = 1'b1; cfg_edge = 2'b11;
    pin_in = ~pin_in; tick();
    pin_in = ~pin_in; tick();
    check("R1 compare ignores pin", cap_count, 0);
    time_wr = 1'b1; time_wdata = 50; tick(); time_wr = 1'b0;
    check("R7 readback", time_rdata, 50);
    clear_pend();

    // R5/R6: every action, both reset settings, two rounds
    exp_pin = 0;
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 4; a++) begin
        int old_pin;
        bit en;
        en = ((a + r) % 2) == 1;
        cfg_action = a[1:0]; cfg_rst_en = en;
        clear_pend();
        old_pin = exp_pin;
        case (a)
          1: exp_pin = 1;
          2: exp_pin = 0;
          3: exp_pin = 1 - exp_pin;
          default: ;
        endcase
        pulses = 0;
        for (int t = 45; t <= 55; t++) begin
          timer_a = TW'(t); tick();
          pulses += int'(timer_rst_req);
          if (t == 49) check("R5 before match", pin_out, old_pin);
          if (t == 50) check("R5 action", pin_out, exp_pin);
          if (t == 50) check("R6 pulse timing", timer_rst_req, int'(en));
        end
        check("R6 pulse count", pulses, int'(en));
        check("R5 pin after sweep", pin_out, exp_pin);
        check("R8 pend on compare", pend, 1);
      end
    end

    // R5: held equality fires once
    cfg_action = 2'b11; cfg_rst_en = 1'b1; pulses = 0;
    timer_a = 50;
    for (int i = 0; i < 5; i++) begin tick(); pulses += int'(timer_rst_req); end
    exp_pin = 1 - exp_pin;
    check("R5 single fire", pin_out, exp_pin);
    check("R6 single pulse", pulses, 1);

    // R7: write takes effect next cycle
    timer_a = 60; tick();
    time_wr = 1'b1; time_wdata = 60; tick(); time_wr = 1'b0;
    check("R7 not before write", pin_out, exp_pin);
    tick();
    exp_pin = 1 - exp_pin;
    check("R7 immediate compare", pin_out, exp_pin);

    // R5: capture mode holds the pin
    cfg_compare = 1'b0; tick(); tick();
    check("R5 hold outside compare", pin_out, exp_pin);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule